// File: doc/BRIEF.md
# Tightly Coupled Scratch Memory Window

This block is a small on-chip RAM placed in front of the system bus. Every CPU load or store is offered to it; when the address falls inside a programmable window and the current mode allows the access, the block reports a hit and serves it. Otherwise it reports a miss, and the surrounding logic sends the access to the bus. The window size is a power of two of at least the physical array size. The physical array is therefore mirrored across the whole window, and the array index is the address masked down to the physical size.

A three-state mode machine governs the access. `MODE_OFF` refuses everything. `MODE_FILL` refuses reads but accepts writes, so software can preload the memory with ordinary stores. `MODE_LIVE` accepts both. A configuration strobe `cfg_wr` loads the enable, the fill control and the window base together. On that strobe the machine takes one of three transitions: *to_off* when the enable is clear, *to_fill* when enable and fill are both set, and *to_live* when enable is set and fill is clear. Reset forces `MODE_OFF`. Reads return data combinationally in the same cycle as the hit flag. Writes commit at the rising clock edge through byte enables, in little-endian lane order.

Top module: `tcm_window`

## Requirements
- R1: After reset the mode is off, and every access (read or write, any address) reports `acc_hit` = 0.
- R2: While the enable is clear, reads and writes both miss, and a write leaves the memory contents unchanged.
- R3: While enable and fill are both set, reads miss with `acc_rdata` = 0, and writes inside the window hit and are stored.
- R4: While enable is set and fill is clear, reads and writes inside the window hit, and a written value is read back.
- R5: An access is inside the window exactly when base <= address < base + VIRT_BYTES. The base is given by its upper bits `cfg_base_hi` (address bits 31 down to log2(VIRT_BYTES)), so the base is always aligned to the window size.
- R6: The storage index is the address modulo PHYS_BYTES, so addresses PHYS_BYTES apart within the window reach the same location.
- R7: Byte lane n (address bits [1:0] = n) holds bits 8n+7..8n of a word. A halfword at address bit 1 = 0 occupies bits 15..0, and one at address bit 1 = 1 occupies bits 31..16.
- R8: The size code on `acc_size` is 0 for byte, 1 for halfword, 2 for word, and 3 is treated as word. A halfword access ignores address bit 0, and a word access ignores address bits 1..0. A byte write changes one byte and a halfword write changes two.
- R9: Byte and halfword read data is zero-extended. `acc_rdata` is valid in the same cycle as `acc_hit` and is 0 on a miss.
- R10: The mode and base change only at a clock edge where `cfg_wr` = 1. An access in that same cycle is judged under the old mode and base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Load strobe for enable, fill and base |
| cfg_enable | input | 1 | Memory enable value to load |
| cfg_fill | input | 1 | Fill (preload) control value to load |
| cfg_base_hi | input | ADDR_W-log2(VIRT_BYTES) | Upper bits of the window base |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| acc_addr | input | ADDR_W | Byte address |
| acc_wdata | input | 32 | Store data, right-aligned |
| acc_hit | output | 1 | Access served by this memory |
| acc_rdata | output | 32 | Zero-extended load data, 0 on miss |

## Verification
A configuration load and an access can fall in the same cycle. The bench provokes this by raising `cfg_wr` to switch from off to live while it presents a store to a location whose value is already known. The store must miss in that cycle because it is judged under the old mode. A later read in live mode must return the earlier value, which shows that the store did not commit. The same collision is repeated in the opposite direction, with live mode switching to off: the store must still hit and commit.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_FILL = 2'd1,
        MODE_LIVE = 2'd2
    } tcm_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD3 = 2'd3
    } tcm_size_e;

    localparam int LANES = 4;

endpackage

// File: rtl/tcm_mode_fsm.sv
module tcm_mode_fsm
    import tcm_pkg::*;
#(
    parameter int BASE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_enable,
    input  logic              cfg_fill,
    input  logic [BASE_W-1:0] cfg_base_hi,
    output tcm_mode_e         mode,
    output logic [BASE_W-1:0] base_hi,
    output logic              rd_ok,
    output logic              wr_ok
);

    tcm_mode_e mode_q, mode_d;
    logic [BASE_W-1:0] base_q;

    // next-state selection: to_off / to_fill / to_live on the load strobe
    always_comb begin
        mode_d = mode_q;
        if (cfg_wr) begin
            if (!cfg_enable)    mode_d = MODE_OFF;
            else if (cfg_fill)  mode_d = MODE_FILL;
            else                mode_d = MODE_LIVE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
            base_q <= '0;
        end else begin
            mode_q <= mode_d;
            if (cfg_wr) base_q <= cfg_base_hi;
        end
    end

    always_comb begin
        rd_ok = 1'b0;
        wr_ok = 1'b0;
        unique case (mode_q)
            MODE_OFF:  begin rd_ok = 1'b0; wr_ok = 1'b0; end
            MODE_FILL: begin rd_ok = 1'b0; wr_ok = 1'b1; end
            MODE_LIVE: begin rd_ok = 1'b1; wr_ok = 1'b1; end
            default:   begin rd_ok = 1'b0; wr_ok = 1'b0; end
        endcase
    end

    assign mode    = mode_q;
    assign base_hi = base_q;

    // R10: mode and base hold unless the strobe was seen at the previous edge
    a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_wr) |-> ($stable(mode_q) && $stable(base_q)));

    // R1: first cycle after reset is off
    a_r1_reset_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n)) |-> (mode_q == MODE_OFF));

endmodule

// File: rtl/tcm_window_cmp.sv
module tcm_window_cmp #(
    parameter int ADDR_W  = 32,
    parameter int VIRT_AW = 12,
    parameter int PHYS_AW = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [ADDR_W-VIRT_AW-1:0] base_hi,
    output logic                      in_win,
    output logic [PHYS_AW-3:0]        word_idx,
    output logic [1:0]                lane
);

    localparam logic [ADDR_W-1:0] VIRT_SPAN = ADDR_W'(1) << VIRT_AW;
    localparam logic [VIRT_AW-1:0] IDX_MASK = VIRT_AW'((1 << PHYS_AW) - 1);

    logic [VIRT_AW-1:0] masked;
    logic [ADDR_W-1:0]  base_full;

    assign base_full = {base_hi, {VIRT_AW{1'b0}}};
    assign in_win    = (addr[ADDR_W-1:VIRT_AW] == base_hi);
    assign masked    = addr[VIRT_AW-1:0] & IDX_MASK;
    assign word_idx  = masked[PHYS_AW-1:2];
    assign lane      = masked[1:0];

    // R5: a match means the offset from the base is inside the span
    a_r5_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        in_win |-> ((addr - base_full) < VIRT_SPAN));

    // R5: no match means the address lies outside the span
    a_r5_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !in_win |-> ((addr < base_full) || ((addr - base_full) >= VIRT_SPAN)));

endmodule

// File: rtl/tcm_lane_unit.sv
module tcm_lane_unit
    import tcm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  size,
    input  logic [1:0]  lane,
    input  logic [31:0] wdata,
    input  logic [31:0] rword,
    output logic [3:0]  be,
    output logic [31:0] wword,
    output logic [31:0] rext
);

    tcm_size_e sz;
    assign sz = tcm_size_e'(size);

    always_comb begin
        be    = 4'b0000;
        wword = wdata;
        rext  = '0;
        unique case (sz)
            SZ_BYTE: begin
                be    = 4'b0001 << lane;
                wword = {4{wdata[7:0]}};
                rext  = {24'd0, rword[8*lane +: 8]};
            end
            SZ_HALF: begin
                be    = lane[1] ? 4'b1100 : 4'b0011;
                wword = {2{wdata[15:0]}};
                rext  = {16'd0, (lane[1] ? rword[31:16] : rword[15:0])};
            end
            SZ_WORD, SZ_WORD3: begin
                be    = 4'b1111;
                wword = wdata;
                rext  = rword;
            end
            default: begin
                be    = 4'b0000;
                wword = wdata;
                rext  = '0;
            end
        endcase
    end

    // R8: byte enables count follows the size code
    a_r8_be_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (sz == SZ_BYTE) |-> ($countones(be) == 1));
    a_r8_be_half: assert property (@(posedge clk) disable iff (!rst_n)
        (sz == SZ_HALF) |-> ($countones(be) == 2));

endmodule

// File: rtl/tcm_bank.sv
module tcm_bank
    import tcm_pkg::*;
#(
    parameter int PHYS_AW = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [3:0]         be,
    input  logic [PHYS_AW-3:0] idx,
    input  logic [31:0]        wword,
    output logic [31:0]        rword
);

    localparam int WORDS = 1 << (PHYS_AW - 2);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] cells [WORDS];

        always_ff @(posedge clk) begin
            if (we && be[g]) cells[idx] <= wword[8*g +: 8];
        end

        assign rword[8*g +: 8] = cells[idx];

        // R4: a committed lane reads back at the same index in the next cycle
        a_r4_lane_commit: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(we && be[g]) && (idx == $past(idx)))
                |-> (rword[8*g +: 8] == $past(wword[8*g +: 8])));
    end

endmodule

// File: rtl/tcm_window.sv
module tcm_window
    import tcm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PHYS_BYTES = 1024,
    parameter int VIRT_BYTES = 4096,
    localparam int PHYS_AW   = $clog2(PHYS_BYTES),
    localparam int VIRT_AW   = $clog2(VIRT_BYTES),
    localparam int BASE_W    = ADDR_W - VIRT_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_enable,
    input  logic              cfg_fill,
    input  logic [BASE_W-1:0] cfg_base_hi,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_size,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [31:0]       acc_wdata,
    output logic              acc_hit,
    output logic [31:0]       acc_rdata
);

    tcm_mode_e          mode;
    logic [BASE_W-1:0]  base_hi;
    logic               rd_ok, wr_ok, in_win, we;
    logic [PHYS_AW-3:0] word_idx;
    logic [1:0]         lane;
    logic [3:0]         be;
    logic [31:0]        wword, rword, rext;

    tcm_mode_fsm #(.BASE_W(BASE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_enable(cfg_enable),
        .cfg_fill(cfg_fill), .cfg_base_hi(cfg_base_hi), .mode(mode),
        .base_hi(base_hi), .rd_ok(rd_ok), .wr_ok(wr_ok)
    );

    tcm_window_cmp #(.ADDR_W(ADDR_W), .VIRT_AW(VIRT_AW), .PHYS_AW(PHYS_AW)) u_cmp (
        .clk(clk), .rst_n(rst_n), .addr(acc_addr), .base_hi(base_hi),
        .in_win(in_win), .word_idx(word_idx), .lane(lane)
    );

    tcm_lane_unit u_lane (
        .clk(clk), .rst_n(rst_n), .size(acc_size), .lane(lane),
        .wdata(acc_wdata), .rword(rword), .be(be), .wword(wword), .rext(rext)
    );

    tcm_bank #(.PHYS_AW(PHYS_AW)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(we), .be(be), .idx(word_idx),
        .wword(wword), .rword(rword)
    );

    always_comb begin
        acc_hit = 1'b0;
        if (acc_valid && in_win)
            acc_hit = acc_write ? wr_ok : rd_ok;
    end

    assign we        = acc_hit && acc_write;
    assign acc_rdata = (acc_hit && !acc_write) ? rext : 32'd0;

    // R2: off mode never reports a hit
    a_r2_off_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |-> !acc_hit);

    // R3: fill mode refuses every read
    a_r3_fill_read_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FILL && acc_valid && !acc_write) |-> (!acc_hit && acc_rdata == 32'd0));

    // R5: a hit is always inside the window
    a_r5_hit_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hit |-> in_win);

    // R9: miss data is zero
    a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_hit |-> (acc_rdata == 32'd0));

endmodule

// File: tb/tcm_window_test.sv
module tcm_window_test;

    localparam int ADDR_W = 32;
    localparam int BASE_W = 20;
    localparam logic [31:0] BASE = 32'h0200_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0, cfg_enable = 1'b0, cfg_fill = 1'b0;
    logic [BASE_W-1:0] cfg_base_hi = '0;
    logic              acc_valid = 1'b0, acc_write = 1'b0;
    logic [1:0]        acc_size = 2'd0;
    logic [31:0]       acc_addr = '0, acc_wdata = '0;
    logic              acc_hit;
    logic [31:0]       acc_rdata;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    tcm_window uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_enable(cfg_enable),
        .cfg_fill(cfg_fill), .cfg_base_hi(cfg_base_hi), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_size(acc_size), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_hit(acc_hit), .acc_rdata(acc_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic configure(input logic en, input logic fl, input logic [31:0] base);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_enable = en; cfg_fill = fl; cfg_base_hi = base[31:12];
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic access(input string tag, input logic wr, input logic [1:0] sz,
                          input logic [31:0] addr, input logic [31:0] wd,
                          input logic exp_hit, input logic [31:0] exp_rd);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_size = sz; acc_addr = addr; acc_wdata = wd;
        #5;
        check({tag, " hit"}, {31'd0, acc_hit}, {31'd0, exp_hit});
        if (!wr) check({tag, " data"}, acc_rdata, exp_rd);
        @(posedge clk); #1;
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic t_reset;
        access("R1 read after reset", 1'b0, 2'd2, BASE, 0, 1'b0, 32'd0);
        access("R1 write after reset", 1'b1, 2'd2, BASE, 32'h1, 1'b0, 32'd0);
    endtask

    task automatic t_fill;
        configure(1'b1, 1'b1, BASE);
        access("R3 fill write", 1'b1, 2'd2, BASE, 32'h1122_3344, 1'b1, 0);
        access("R3 fill read miss", 1'b0, 2'd2, BASE, 0, 1'b0, 32'd0);
    endtask

    task automatic t_disabled;
        configure(1'b0, 1'b0, BASE);
        access("R2 off write", 1'b1, 2'd2, BASE, 32'hDEAD_BEEF, 1'b0, 0);
        access("R2 off read", 1'b0, 2'd2, BASE, 0, 1'b0, 32'd0);
        configure(1'b1, 1'b0, BASE);
        access("R2 contents kept", 1'b0, 2'd2, BASE, 0, 1'b1, 32'h1122_3344);
    endtask

    task automatic t_lanes;
        access("R4 live write", 1'b1, 2'd2, BASE + 32'h10, 32'hA1B2_C3D4, 1'b1, 0);
        access("R4 live read", 1'b0, 2'd2, BASE + 32'h10, 0, 1'b1, 32'hA1B2_C3D4);
        access("R7 byte lane1", 1'b0, 2'd0, BASE + 32'h11, 0, 1'b1, 32'h0000_00C3);
        access("R7 half upper", 1'b0, 2'd1, BASE + 32'h12, 0, 1'b1, 32'h0000_A1B2);
        access("R8 byte write", 1'b1, 2'd0, BASE + 32'h13, 32'hFFFF_FF5A, 1'b1, 0);
        access("R8 after byte", 1'b0, 2'd2, BASE + 32'h10, 0, 1'b1, 32'h5AB2_C3D4);
        access("R8 half write", 1'b1, 2'd1, BASE + 32'h11, 32'h0000_7788, 1'b1, 0);
        access("R8 after half", 1'b0, 2'd2, BASE + 32'h10, 0, 1'b1, 32'h5AB2_7788);
        access("R8 half a0 ignored", 1'b0, 2'd1, BASE + 32'h13, 0, 1'b1, 32'h0000_5AB2);
        access("R8 size3 word", 1'b0, 2'd3, BASE + 32'h12, 0, 1'b1, 32'h5AB2_7788);
        access("R9 byte zero ext", 1'b0, 2'd0, BASE + 32'h13, 0, 1'b1, 32'h0000_005A);
    endtask

    task automatic t_window;
        access("R5 top write", 1'b1, 2'd2, BASE + 32'hFFC, 32'hCAFE_0001, 1'b1, 0);
        access("R5 top read", 1'b0, 2'd2, BASE + 32'hFFC, 0, 1'b1, 32'hCAFE_0001);
        access("R5 below base", 1'b0, 2'd2, BASE - 32'h4, 0, 1'b0, 32'd0);
        access("R5 end exclusive", 1'b0, 2'd2, BASE + 32'h1000, 0, 1'b0, 32'd0);
        access("R5 end write miss", 1'b1, 2'd2, BASE + 32'h1000, 32'h0BAD_0BAD, 1'b0, 0);
        access("R5 top kept", 1'b0, 2'd2, BASE + 32'hFFC, 0, 1'b1, 32'hCAFE_0001);
        configure(1'b1, 1'b0, 32'h0300_0000);
        access("R5 old base miss", 1'b0, 2'd2, BASE, 0, 1'b0, 32'd0);
        access("R5 new base hit", 1'b0, 2'd2, 32'h0300_0000, 0, 1'b1, 32'h1122_3344);
        configure(1'b1, 1'b0, BASE);
    endtask

    task automatic t_mirror;
        access("R6 write", 1'b1, 2'd2, BASE + 32'h20, 32'h600D_F00D, 1'b1, 0);
        access("R6 mirror read", 1'b0, 2'd2, BASE + 32'h420, 0, 1'b1, 32'h600D_F00D);
        access("R6 high write", 1'b1, 2'd2, BASE + 32'hC24, 32'h0123_4567, 1'b1, 0);
        access("R6 low read", 1'b0, 2'd2, BASE + 32'h24, 0, 1'b1, 32'h0123_4567);
    endtask

    task automatic t_collide;
        access("R10 seed", 1'b1, 2'd2, BASE + 32'h30, 32'h0000_0000, 1'b1, 0);
        configure(1'b0, 1'b0, BASE);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_enable = 1'b1; cfg_fill = 1'b0; cfg_base_hi = BASE[31:12];
        acc_valid = 1'b1; acc_write = 1'b1; acc_size = 2'd2;
        acc_addr = BASE + 32'h30; acc_wdata = 32'hFFFF_FFFF;
        #5;
        check("R10 same-cycle store misses", {31'd0, acc_hit}, 32'd0);
        @(posedge clk); #1;
        cfg_wr = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
        access("R10 store not committed", 1'b0, 2'd2, BASE + 32'h30, 0, 1'b1, 32'd0);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_enable = 1'b0;
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = BASE + 32'h30; acc_wdata = 32'h7777_7777;
        #5;
        check("R10 old mode store hits", {31'd0, acc_hit}, 32'd1);
        @(posedge clk); #1;
        cfg_wr = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
        configure(1'b1, 1'b0, BASE);
        access("R10 store committed", 1'b0, 2'd2, BASE + 32'h30, 0, 1'b1, 32'h7777_7777);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset;
        t_fill;
        t_disabled;
        t_lanes;
        t_window;
        t_mirror;
        t_collide;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule